// File: doc/BRIEF.md
# DMX512 Universe Frame Transmitter

This block drives one serial lighting-control line with an endless series of DMX512 frames for a single universe. A host fills a small slot memory through a simple write port, at any time. The transmitter runs on its own. Each frame pulls the line low for a break and releases it high for a mark-after-break. It then sends a zero start code followed by every slot value in ascending address order. Optional idle gaps can separate slots, and an optional mark can follow the last slot. The line then idles high until the refresh period has run out, and the next frame starts.

Every duration is a compile-time parameter, given in microseconds (or in hertz for the bit rate and refresh rate) and converted to clock cycles from the system clock frequency. The clock frequency must be a whole number of megahertz and a whole multiple of the bit rate. Each slot goes out as a low start bit, eight data bits least significant first, and two high stop bits. The whole 8-bit value is captured in one cycle when its slot begins, so a host write never splits a byte on the line.

The sequencer is a state machine with six states: BREAK, MAB, SLOT, GAP, MBB and FILL. Its transitions are as follows:
- BREAK→MAB when the break time ends.
- MAB→SLOT when the mark ends; this loads the start code.
- SLOT→SLOT at the end of a slot when the inter-slot gap is zero; this loads the next slot.
- SLOT→GAP at the end of a slot when the gap is non-zero.
- GAP→SLOT when the gap ends.
- After the last slot, SLOT→MBB when a mark-before-break is configured. Otherwise the last slot leads directly to FILL or BREAK.
- MBB→FILL when refresh time remains, or MBB→BREAK when the period has already run out.
- FILL→BREAK when the refresh period expires.

Reset holds the sequencer in BREAK. The line stays high until reset is released, and the first frame begins on the first cycle after release.

Top module: `dmx_frame_tx`

## Requirements
- R1: Each frame starts with the line low for exactly BREAK_US×(CLK_HZ/1e6) cycles; `frame_start` is high for one cycle, the first cycle of that break.
- R2: The break is followed by the line high for exactly MAB_US×(CLK_HZ/1e6) cycles.
- R3: Each slot lasts 11×(CLK_HZ/BIT_HZ) cycles: bit 0 low (start), bits 1 to 8 the data byte least significant bit first, bits 9 and 10 high (stop).
- R4: The first slot of a frame carries 0x00, followed by SLOTS slots carrying memory addresses 0, 1, … SLOTS−1 in that order.
- R5: Consecutive slots are separated by exactly IBT_US×(CLK_HZ/1e6) high cycles; with zero, the next start bit follows the last stop bit directly.
- R6: After the last slot the line stays high with `busy` high for exactly MBB_US×(CLK_HZ/1e6) cycles.
- R7: Consecutive `frame_start` pulses are exactly CLK_HZ/REFRESH_HZ cycles apart when the frame fits in that period. The remaining cycles hold the line high with `busy` low.
- R8: When a frame is longer than the refresh period, the next break begins on the cycle after the mark-before-break ends, with no idle cycles; no frame is dropped.
- R9: While `rst` is high, `dmx_out` is high and `frame_start` is low. On the first cycle after release, `frame_start` is high and the break begins.
- R10: A write during a frame changes any slot only as a whole byte. A frame that starts after the write carries the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Slot memory write strobe |
| wr_addr | input | $clog2(SLOTS) | Slot memory write address (0 is the first data slot) |
| wr_data | input | 8 | Slot value to write |
| dmx_out | output | 1 | Serial line, idle high |
| busy | output | 1 | High from the break through the mark-before-break, low while idling |
| frame_start | output | 1 | One-cycle strobe on the first break cycle |

## Verification
The checker watches every cycle for the following: the line is high whenever `busy` is low; the line is high during reset; `frame_start` always coincides with a low line; each break lasts the exact parameter length; and two frame starts are never closer than the refresh period. The bench's scenarios must show the rest. These are the bit-level slot format and its sample points, the ordering of start code and data, the inter-slot gap and mark-before-break lengths, the exact period, and the direct break in the overrun case. They also cover how a host write that lands mid-frame appears in that frame and in the next.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

    typedef enum logic [2:0] {
        ST_BREAK,
        ST_MAB,
        ST_SLOT,
        ST_GAP,
        ST_MBB,
        ST_FILL
    } dmx_state_e;

    localparam logic [7:0] START_CODE = 8'h00;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dmx_slot_ram.sv
module dmx_slot_ram #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem [DEPTH];

    // Host port writes, sequencer port reads every cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/dmx_slot_serializer.sv
module dmx_slot_serializer #(
    parameter int BIT_CYC = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] data,
    output logic       line,
    output logic       last
);

    localparam int CW      = $clog2(BIT_CYC + 1);
    localparam int NBITS   = 11;
    localparam logic [3:0] LAST_BIT = 4'(NBITS - 1);

    logic [NBITS-1:0] shreg;
    logic [CW-1:0]    cyc;
    logic [3:0]       bitc;
    logic             active;
    logic             bit_end;

    assign bit_end = active && (cyc == CW'(BIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            cyc    <= '0;
            bitc   <= '0;
            active <= 1'b0;
        end else if (load) begin
            // stop, stop, data LSB first, start
            shreg  <= {2'b11, data, 1'b0};
            cyc    <= '0;
            bitc   <= '0;
            active <= 1'b1;
        end else if (bit_end) begin
            cyc   <= '0;
            shreg <= {1'b1, shreg[NBITS-1:1]};
            bitc  <= bitc + 4'd1;
            if (bitc == LAST_BIT) begin
                active <= 1'b0;
            end
        end else if (active) begin
            cyc <= cyc + CW'(1);
        end
    end

    assign last = bit_end && (bitc == LAST_BIT);
    assign line = active ? shreg[0] : 1'b1;

endmodule

// File: rtl/dmx_refresh_ctr.sv
module dmx_refresh_ctr #(
    parameter int PERIOD = 2272727
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic due
);

    localparam int RW = $clog2(PERIOD + 1) + 1;

    logic [RW-1:0] cnt;

    // Counts cycles since the current frame's first break cycle; saturates.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + RW'(1);
        end
    end

    assign due = (cnt >= RW'(PERIOD - 1));

endmodule

// File: rtl/dmx_frame_tx.sv
module dmx_frame_tx #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BIT_HZ     = 250_000,
    parameter int BREAK_US   = 88,
    parameter int MAB_US     = 8,
    parameter int IBT_US     = 0,
    parameter int MBB_US     = 0,
    parameter int REFRESH_HZ = 44,
    parameter int SLOTS      = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [$clog2(SLOTS)-1:0]  wr_addr,
    input  logic [7:0]                wr_data,
    output logic                      dmx_out,
    output logic                      busy,
    output logic                      frame_start
);
    import dmx_tx_pkg::*;

    localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
    localparam int BIT_CYC     = CLK_HZ / BIT_HZ;
    localparam int BREAK_CYC   = CYC_PER_US * BREAK_US;
    localparam int MAB_CYC     = CYC_PER_US * MAB_US;
    localparam int IBT_CYC     = CYC_PER_US * IBT_US;
    localparam int MBB_CYC     = CYC_PER_US * MBB_US;
    localparam int REFRESH_CYC = CLK_HZ / REFRESH_HZ;
    localparam int ADDR_W      = $clog2(SLOTS);
    localparam int LD_W        = $clog2(SLOTS + 2);
    localparam int PH_MAX      = imax(imax(BREAK_CYC, MAB_CYC), imax(IBT_CYC, MBB_CYC));
    localparam int TW          = $clog2(PH_MAX + 1) + 1;
    localparam logic [LD_W-1:0] LD_END = LD_W'(SLOTS + 1);

    dmx_state_e        state, state_nx;
    logic [TW-1:0]     tcnt;
    logic [LD_W-1:0]   loaded;
    logic              ld;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic [7:0]        ld_data;
    logic              ser_line, ser_last;
    logic              ref_due, ref_restart;

    // ---------------- sub-blocks ----------------
    dmx_slot_ram #(.DEPTH(SLOTS), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    dmx_slot_serializer #(.BIT_CYC(BIT_CYC)) u_ser (
        .clk  (clk),
        .rst  (rst),
        .load (ld),
        .data (ld_data),
        .line (ser_line),
        .last (ser_last)
    );

    dmx_refresh_ctr #(.PERIOD(REFRESH_CYC)) u_ref (
        .clk     (clk),
        .rst     (rst),
        .restart (ref_restart),
        .due     (ref_due)
    );

    // Read pointer runs one slot ahead of the serializer.
    assign rd_addr = (loaded == '0) ? '0 : ADDR_W'(loaded - LD_W'(1));
    assign ld_data = (loaded == '0) ? START_CODE : rd_data;
    assign ref_restart = (state_nx == ST_BREAK) && (state != ST_BREAK);

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        ld       = 1'b0;
        unique case (state)
            ST_BREAK: begin
                if (tcnt == TW'(BREAK_CYC - 1)) state_nx = ST_MAB;
            end
            ST_MAB: begin
                if (tcnt == TW'(MAB_CYC - 1)) begin
                    state_nx = ST_SLOT;
                    ld       = 1'b1;
                end
            end
            ST_SLOT: begin
                if (ser_last) begin
                    if (loaded == LD_END) begin
                        if (MBB_CYC > 0)  state_nx = ST_MBB;
                        else if (ref_due) state_nx = ST_BREAK;
                        else              state_nx = ST_FILL;
                    end else if (IBT_CYC > 0) begin
                        state_nx = ST_GAP;
                    end else begin
                        ld = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tcnt == TW'(IBT_CYC - 1)) begin
                    state_nx = ST_SLOT;
                    ld       = 1'b1;
                end
            end
            ST_MBB: begin
                if (tcnt == TW'(MBB_CYC - 1)) begin
                    state_nx = ref_due ? ST_BREAK : ST_FILL;
                end
            end
            ST_FILL: begin
                if (ref_due) state_nx = ST_BREAK;
            end
            default: state_nx = ST_BREAK;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_BREAK;
            tcnt   <= '0;
            loaded <= '0;
        end else begin
            state <= state_nx;
            tcnt  <= (state_nx != state) ? '0 : tcnt + TW'(1);
            if (state == ST_BREAK) begin
                loaded <= '0;
            end else if (ld) begin
                loaded <= loaded + LD_W'(1);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        dmx_out     = 1'b1;
        busy        = 1'b1;
        frame_start = 1'b0;
        if (rst) begin
            busy = 1'b0;
        end else begin
            unique case (state)
                ST_BREAK: begin
                    dmx_out     = 1'b0;
                    frame_start = (tcnt == '0);
                end
                ST_SLOT:  dmx_out = ser_line;
                ST_FILL:  busy    = 1'b0;
                ST_MAB, ST_GAP, ST_MBB: dmx_out = 1'b1;
                default:  dmx_out = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/dmx_frame_tx_chk.sv
module dmx_frame_tx_chk #(
    parameter int BRK_CYC = 8800,
    parameter int REF_CYC = 2272727
) (
    input logic clk,
    input logic rst,
    input logic dmx_out,
    input logic busy,
    input logic frame_start
);

    logic [31:0] brk_cnt;
    logic        in_brk;
    logic [31:0] per_cnt;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_cnt <= '0;
            in_brk  <= 1'b0;
            per_cnt <= '0;
            seen    <= 1'b0;
        end else begin
            if (frame_start) begin
                in_brk  <= 1'b1;
                brk_cnt <= 32'd1;
                per_cnt <= 32'd1;
                seen    <= 1'b1;
            end else begin
                if (in_brk && !dmx_out) brk_cnt <= brk_cnt + 32'd1;
                if (in_brk && dmx_out)  in_brk  <= 1'b0;
                if (per_cnt != '1)      per_cnt <= per_cnt + 32'd1;
            end
        end
    end

    // R9
    always @(posedge clk) begin
        if (rst) begin
            reset_line_high_chk: assert (dmx_out && !frame_start);
        end
    end

    // R1
    strobe_in_break_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (!dmx_out && busy));

    // R1
    break_length_chk: assert property (@(posedge clk) disable iff (rst)
        (in_brk && dmx_out && !frame_start) |-> (brk_cnt == 32'(BRK_CYC)));

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> dmx_out);

    // R7
    min_period_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && seen) |-> (per_cnt >= 32'(REF_CYC)));

    // R1
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

bind dmx_frame_tx dmx_frame_tx_chk #(
    .BRK_CYC (BREAK_CYC),
    .REF_CYC (REFRESH_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dmx_out     (dmx_out),
    .busy        (busy),
    .frame_start (frame_start)
);

// File: tb/dmx_frame_tx_test.sv
`timescale 1ns/1ps
module dmx_frame_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS    = 8;
    localparam int AW    = 3;
    localparam int BITC  = 4;
    localparam int BRK   = 88;
    localparam int MABC  = 8;
    localparam int IBT2  = 3;
    localparam int MBB2  = 20;
    localparam int REF1  = 1000;
    localparam int LEN1  = BRK + MABC + (NS + 1) * 11 * BITC;
    localparam int LEN2  = LEN1 + NS * IBT2 + MBB2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic we  = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [7:0]    wd = '0;
    logic o1, b1, f1, o2, b2, f2;
    logic sel = 1'b0;
    logic line, bsy, fs;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmx_frame_tx #(.CLK_HZ(1_000_000), .REFRESH_HZ(1000), .SLOTS(NS)) uut (
        .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .dmx_out(o1), .busy(b1), .frame_start(f1));

    dmx_frame_tx #(.CLK_HZ(1_000_000), .IBT_US(IBT2), .MBB_US(MBB2),
                   .REFRESH_HZ(4000), .SLOTS(NS)) uut_ovr (
        .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .dmx_out(o2), .busy(b2), .frame_start(f2));

    assign line = sel ? o2 : o1;
    assign bsy  = sel ? b2 : b1;
    assign fs   = sel ? f2 : f1;

    logic [7:0] model [NS];
    logic [7:0] prev  [NS];
    int f_brk, f_mab, f_fmt, f_mbb, f_fill, f_lowfill, f_period;
    int f_gap  [NS];
    logic [7:0] f_data [NS+1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        we = 1'b1; wa = AW'(a); wd = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    function automatic logic [7:0] corner(input int i);
        logic [7:0] v [8] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80, 8'h7F, 8'hFE};
        return v[i % 8];
    endfunction

    // Decode one frame, sampling each bit in its middle.
    task automatic grab();
        int t0;
        logic [10:0] bits;
        while (!fs) @(negedge clk);
        t0 = cyc;
        f_brk = 0; f_mab = 0; f_fmt = 0; f_mbb = 0; f_fill = 0; f_lowfill = 0;
        while (!line) begin f_brk++; @(negedge clk); end
        while (line)  begin f_mab++; @(negedge clk); end
        for (int s = 0; s <= NS; s++) begin
            repeat (2) @(negedge clk);
            for (int b = 0; b < 11; b++) begin
                bits[b] = line;
                if (b < 10) repeat (BITC) @(negedge clk);
            end
            repeat (2) @(negedge clk);
            if (bits[0] != 1'b0 || bits[9] != 1'b1 || bits[10] != 1'b1) f_fmt++;
            f_data[s] = bits[8:1];
            if (s < NS) begin
                f_gap[s] = 0;
                while (line) begin f_gap[s]++; @(negedge clk); end
            end
        end
        while (bsy && !fs) begin
            if (!line) f_lowfill++;
            f_mbb++; @(negedge clk);
        end
        while (!fs) begin
            if (!line || bsy) f_lowfill++;
            f_fill++; @(negedge clk);
        end
        f_period = cyc - t0;
    endtask

    task automatic check_timing(input int gap_e, input int mbb_e, input int per_e);
        chk(f_brk == BRK, "R1 break length", f_brk, BRK);
        chk(f_mab == MABC, "R2 mark-after-break", f_mab, MABC);
        chk(f_fmt == 0, "R3 start/stop bits", f_fmt, 0);
        for (int s = 0; s < NS; s++)
            chk(f_gap[s] == gap_e, "R5 inter-slot gap", f_gap[s], gap_e);
        chk(f_mbb == mbb_e, "R6 mark-before-break", f_mbb, mbb_e);
        chk(f_lowfill == 0, "R7 idle/mark level", f_lowfill, 0);
        chk(f_period == per_e, "R7 frame period", f_period, per_e);
    endtask

    task automatic check_data();
        chk(f_data[0] == 8'h00, "R4 start code", int'(f_data[0]), 0);
        for (int s = 0; s < NS; s++)
            chk(f_data[s+1] == model[s], "R4 slot value", int'(f_data[s+1]), int'(model[s]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            model[s] = 8'($urandom);
            wr(s, model[s]);
        end
        // R9: reset state
        for (int i = 0; i < 4; i++) begin
            chk(o1 == 1'b1 && o2 == 1'b1, "R9 line high in reset", int'(o1 & o2), 1);
            chk(f1 == 1'b0, "R9 no strobe in reset", int'(f1), 0);
            @(negedge clk);
        end
        rst = 1'b0;
        #1;
        chk(f1 == 1'b1 && o1 == 1'b0, "R9 break right after reset", int'(f1), 1);

        grab();
        check_timing(0, 0, REF1);
        check_data();
        chk(f_fill == REF1 - LEN1, "R7 idle fill length", f_fill, REF1 - LEN1);

        // R10: writes land mid-frame, next frame must carry all of them
        for (int it = 0; it < 3; it++) begin
            for (int s = 0; s < NS; s++) prev[s] = model[s];
            for (int s = 0; s < NS; s++)
                model[s] = (it == 1) ? corner(s) : 8'($urandom);
            fork
                grab();
                begin
                    repeat (150 + 60 * it) @(negedge clk);
                    for (int s = 0; s < NS; s++) wr(s, model[s]);
                end
            join
            chk(f_fmt == 0, "R10 whole bytes", f_fmt, 0);
            for (int s = 0; s < NS; s++)
                chk(f_data[s+1] == model[s] || f_data[s+1] == prev[s],
                    "R10 old-or-new byte", int'(f_data[s+1]), int'(model[s]));
            grab();
            check_timing(0, 0, REF1);
            check_data();
        end

        // R8: frame longer than refresh period
        sel = 1'b1;
        #1;
        grab();
        check_timing(IBT2, MBB2, LEN2);
        check_data();
        chk(f_fill == 0, "R8 no idle before next break", f_fill, 0);
        grab();
        chk(f_period == LEN2, "R8 repeat without skipping", f_period, LEN2);
        chk(f_gap[NS-1] == IBT2, "R5 gap before last slot", f_gap[NS-1], IBT2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule